// File: doc/BRIEF.md
# Multi-Accumulator Multiply-Accumulate Unit

This execution unit multiplies two 32-bit register operands and combines the 64-bit product with one of four 64-bit accumulators. Each accumulator is a high word and a low word. The product can replace the accumulator, be added to it, or be subtracted from it, in signed or unsigned form. The unit also moves a register value into one accumulator word, and returns one accumulator word to a destination register through a write port.

The unit takes a 32-bit instruction word and two operand values read from the register file. A 2-bit field inside the instruction selects the accumulator. Index 0 is the legacy high/low pair, and indices 1 to 3 are extra pairs that work independently of it. Each operation takes one cycle while the valid strobe is high. An instruction word the unit does not accept raises an illegal flag and leaves all state unchanged.

Top module: `mac_acc_unit`

## Requirements
- R1: A synchronous active-high reset clears all eight accumulator words to zero.
- R2: The product forms use major opcode 000000 with the accumulator index in bits 12:11 and bits 15:13 and 10:6 zero. Function 011000 is signed and function 011001 is unsigned. Each one overwrites the selected accumulator with the 64-bit product: the high half goes to the high word and the low half to the low word.
- R3: Major opcode 011100, with the same layout as R2, uses function 000000 for signed add and function 000001 for unsigned add. Each stores {high,low} plus the product.
- R4: Function 000100 (signed) and function 000101 (unsigned) under major opcode 011100 store {high,low} minus the product.
- R5: Signed forms sign-extend both operands to 64 bits and unsigned forms zero-extend them. Add and subtract wrap modulo 2^64, with no saturation and no flag.
- R6: A move-from uses major opcode 000000 with function 010000 (high word) or 010010 (low word). The index is in bits 22:21, bits 25:23, 20:16 and 10:6 are zero, and the destination register number is in bits 15:11. In the same cycle the unit drives the selected word on the write-data port, raises write-enable and drives the destination number on the write address.
- R7: A move-to uses major opcode 000000 with function 010001 (high word) or 010011 (low word). The index is in bits 12:11 and bits 20:13 and 10:6 are zero. It writes the first operand into only that word and leaves the other word unchanged.
- R8: An operation changes only the accumulator it selects. The other three keep their values.
- R9: When a reserved-zero field is nonzero, the unit raises the illegal flag for that cycle. It does not raise write-enable and it changes no accumulator.
- R10: An opcode/function pair outside R2, R3, R4, R6 and R7 raises the illegal flag and changes no state.
- R11: With valid low, no instruction takes effect. Write-enable and the illegal flag stay low and no accumulator changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | First operand value |
| rt_val_i | input | 32 | Second operand value |
| wr_en_o | output | 1 | Destination register write enable |
| wr_addr_o | output | 5 | Destination register number |
| wr_data_o | output | 32 | Destination register write data |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
Two functions can coincide in one cycle: an accumulator write at a clock edge, and a move-from in the cycle right after it that reads the same pair. The bench provokes this by issuing reads back to back behind every multiply, add, subtract and move-to. The read must return the value produced by that edge and not the old one. A second coincidence is a rejected word arriving in the same slot where a state change would happen. This is judged by reading back all four pairs after each illegal or invalid slot, where every word must be unchanged.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DATA_W    = 32;
    localparam int ACC_W     = 2 * DATA_W;
    localparam int NUM_ACC   = 4;
    localparam int ACC_IDX_W = $clog2(NUM_ACC);
    localparam int REG_IDX_W = 5;

    localparam logic [5:0] OPC_BASE  = 6'b000000;
    localparam logic [5:0] OPC_ACCUM = 6'b011100;

    localparam logic [5:0] FN_MADD  = 6'b000000;
    localparam logic [5:0] FN_MADDU = 6'b000001;
    localparam logic [5:0] FN_MSUB  = 6'b000100;
    localparam logic [5:0] FN_MSUBU = 6'b000101;
    localparam logic [5:0] FN_MULT  = 6'b011000;
    localparam logic [5:0] FN_MULTU = 6'b011001;
    localparam logic [5:0] FN_MFHI  = 6'b010000;
    localparam logic [5:0] FN_MFLO  = 6'b010010;
    localparam logic [5:0] FN_MTHI  = 6'b010001;
    localparam logic [5:0] FN_MTLO  = 6'b010011;

    typedef enum logic [3:0] {
        K_NONE,
        K_MUL_S, K_MUL_U,
        K_ADD_S, K_ADD_U,
        K_SUB_S, K_SUB_U,
        K_RD_HI, K_RD_LO,
        K_WR_HI, K_WR_LO
    } op_kind_e;

    typedef struct packed {
        op_kind_e                kind;
        logic [ACC_IDX_W-1:0]    acc;
        logic [REG_IDX_W-1:0]    rd;
        logic                    bad;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } acc_t;

    function automatic logic kind_is_product(op_kind_e k);
        return (k == K_MUL_S) || (k == K_MUL_U) || (k == K_ADD_S) ||
               (k == K_ADD_U) || (k == K_SUB_S) || (k == K_SUB_U);
    endfunction

    function automatic logic kind_is_signed(op_kind_e k);
        return (k == K_MUL_S) || (k == K_ADD_S) || (k == K_SUB_S);
    endfunction

    function automatic logic [ACC_W-1:0] widen(logic [DATA_W-1:0] v, logic sgn);
        return {{DATA_W{sgn & v[DATA_W-1]}}, v};
    endfunction

endpackage

// File: rtl/mac_decoder.sv
module mac_decoder
    import mac_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic       z_mid_acc;
    logic       z_shamt;
    logic       z_rt;
    logic       z_rs_hi;

    assign opc       = instr[31:26];
    assign fn        = instr[5:0];
    assign z_mid_acc = (instr[15:13] == 3'b000);
    assign z_shamt   = (instr[10:6] == 5'b00000);
    assign z_rt      = (instr[20:16] == 5'b00000);
    assign z_rs_hi   = (instr[25:23] == 3'b000);

    always_comb begin
        dec.kind = K_NONE;
        dec.acc  = instr[12:11];
        dec.rd   = instr[15:11];
        dec.bad  = 1'b1;
        if (opc == OPC_ACCUM) begin
            unique case (fn)
                FN_MADD:  dec.kind = K_ADD_S;
                FN_MADDU: dec.kind = K_ADD_U;
                FN_MSUB:  dec.kind = K_SUB_S;
                FN_MSUBU: dec.kind = K_SUB_U;
                default:  dec.kind = K_NONE;
            endcase
            dec.bad = (dec.kind == K_NONE) || !z_mid_acc || !z_shamt;
        end else if (opc == OPC_BASE) begin
            unique case (fn)
                FN_MULT: begin
                    dec.kind = K_MUL_S;
                    dec.bad  = !z_mid_acc || !z_shamt;
                end
                FN_MULTU: begin
                    dec.kind = K_MUL_U;
                    dec.bad  = !z_mid_acc || !z_shamt;
                end
                FN_MFHI, FN_MFLO: begin
                    dec.kind = (fn == FN_MFHI) ? K_RD_HI : K_RD_LO;
                    dec.acc  = instr[22:21];
                    dec.bad  = !z_rs_hi || !z_rt || !z_shamt;
                end
                FN_MTHI, FN_MTLO: begin
                    dec.kind = (fn == FN_MTHI) ? K_WR_HI : K_WR_LO;
                    dec.bad  = !z_rt || !z_mid_acc || !z_shamt;
                end
                default: begin
                    dec.kind = K_NONE;
                    dec.bad  = 1'b1;
                end
            endcase
        end
        if (dec.bad) dec.kind = K_NONE;
    end
endmodule

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sgn,
    output logic [ACC_W-1:0]  prod
);
    logic [ACC_W-1:0] a_w;
    logic [ACC_W-1:0] b_w;

    assign a_w  = widen(a, sgn);
    assign b_w  = widen(b, sgn);
    assign prod = a_w * b_w;
endmodule

// File: rtl/mac_acc_file.sv
module mac_acc_file
    import mac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_hi,
    input  logic                 we_lo,
    input  logic [ACC_IDX_W-1:0] idx,
    input  logic [DATA_W-1:0]    wdata_hi,
    input  logic [DATA_W-1:0]    wdata_lo,
    output acc_t                 rdata
);
    acc_t bank [NUM_ACC];

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        logic sel;
        assign sel = (idx == ACC_IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else begin
                if (sel && we_hi) bank[g].hi <= wdata_hi;
                if (sel && we_lo) bank[g].lo <= wdata_lo;
            end
        end
    end

    assign rdata = bank[idx];
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
    import mac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic        wr_en_o,
    output logic [4:0]  wr_addr_o,
    output logic [31:0] wr_data_o,
    output logic        illegal_o
);
    dec_t             dec;
    acc_t             cur;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] next_val;
    logic             act;
    logic             acc_we_hi;
    logic             acc_we_lo;
    logic [DATA_W-1:0] wd_hi;
    logic [DATA_W-1:0] wd_lo;

    mac_decoder i_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    mac_product i_prod (
        .a    (rs_val_i),
        .b    (rt_val_i),
        .sgn  (kind_is_signed(dec.kind)),
        .prod (prod)
    );

    assign act = valid_i && !dec.bad;

    always_comb begin
        unique case (dec.kind)
            K_ADD_S, K_ADD_U: next_val = {cur.hi, cur.lo} + prod;
            K_SUB_S, K_SUB_U: next_val = {cur.hi, cur.lo} - prod;
            default:          next_val = prod;
        endcase
    end

    assign acc_we_hi = act && (kind_is_product(dec.kind) || dec.kind == K_WR_HI);
    assign acc_we_lo = act && (kind_is_product(dec.kind) || dec.kind == K_WR_LO);
    assign wd_hi     = (dec.kind == K_WR_HI) ? rs_val_i : next_val[ACC_W-1:DATA_W];
    assign wd_lo     = (dec.kind == K_WR_LO) ? rs_val_i : next_val[DATA_W-1:0];

    mac_acc_file i_accs (
        .clk      (clk),
        .rst      (rst),
        .we_hi    (acc_we_hi),
        .we_lo    (acc_we_lo),
        .idx      (dec.acc),
        .wdata_hi (wd_hi),
        .wdata_lo (wd_lo),
        .rdata    (cur)
    );

    assign wr_en_o   = act && (dec.kind == K_RD_HI || dec.kind == K_RD_LO);
    assign wr_addr_o = dec.rd;
    assign wr_data_o = (dec.kind == K_RD_HI) ? cur.hi : cur.lo;
    assign illegal_o = valid_i && dec.bad;
endmodule

// File: rtl/mac_acc_unit_chk.sv
module mac_acc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic        illegal_o,
    input logic        wr_en_o,
    input logic [31:0] wr_data_o,
    input logic        acc_we_hi,
    input logic        acc_we_lo
);
    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!wr_en_o && !acc_we_hi && !acc_we_lo));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> (!wr_en_o && !illegal_o && !acc_we_hi && !acc_we_lo));

    // R6
    read_no_update_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (!acc_we_hi && !acc_we_lo));

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && wr_en_o) |-> (wr_data_o == 32'h0));

    // R10
    illegal_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> valid_i);
endmodule

bind mac_acc_unit mac_acc_unit_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .illegal_o (illegal_o),
    .wr_en_o   (wr_en_o),
    .wr_data_o (wr_data_o),
    .acc_we_hi (acc_we_hi),
    .acc_we_lo (acc_we_lo)
);

// File: tb/test_mac_acc_unit.sv
module test_mac_acc_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic        wr_en_o;
    logic [4:0]  wr_addr_o;
    logic [31:0] wr_data_o;
    logic        illegal_o;

    mac_acc_unit i_mac_acc_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .illegal_o(illegal_o)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        bit          ill;
        logic [31:0] data;
        logic [4:0]  rd;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] mhi [4];
    logic [31:0] mlo [4];
    bit          done = 0;

    function automatic [31:0] enc_acc(input [5:0] op, input [5:0] fn, input [1:0] idx);
        return {op, 5'd3, 5'd7, 3'b000, idx, 5'b00000, fn};
    endfunction
    function automatic [31:0] enc_mf(input [5:0] fn, input [1:0] idx, input [4:0] rd);
        return {6'b000000, 3'b000, idx, 5'b00000, rd, 5'b00000, fn};
    endfunction
    function automatic [31:0] enc_mt(input [5:0] fn, input [1:0] idx);
        return {6'b000000, 5'd9, 5'b00000, 3'b000, idx, 5'b00000, fn};
    endfunction

    // monitor: pops one expected item for every output event
    always @(negedge clk) begin
        if (!rst && (wr_en_o || illegal_o)) begin
            exp_t e;
            n_tests++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected output wr_en=%0b ill=%0b data=%h expected none",
                         wr_en_o, illegal_o, wr_data_o);
            end else begin
                e = q.pop_front();
                if (e.ill) begin
                    if (!illegal_o || wr_en_o) begin
                        n_fail++;
                        $display("FAIL %s ill=%0b wr_en=%0b expected ill=1 wr_en=0",
                                 e.req, illegal_o, wr_en_o);
                    end
                end else if (!wr_en_o || illegal_o || wr_data_o !== e.data || wr_addr_o !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s en=%0b ill=%0b data=%h rd=%0d expected data=%h rd=%0d",
                             e.req, wr_en_o, illegal_o, wr_data_o, wr_addr_o, e.data, e.rd);
                end
            end
        end
    end

    task automatic issue(input [31:0] ins, input [31:0] a, input [31:0] b);
        valid_i = 1'b1; instr_i = ins; rs_val_i = a; rt_val_i = b;
        @(posedge clk); #1;
        valid_i = 1'b0;
    endtask

    task automatic mac_op(input [5:0] op, input [5:0] fn, input [1:0] idx,
                          input [31:0] a, input [31:0] b);
        logic [63:0] ea, eb, p, cur;
        bit sgn;
        sgn = (fn[0] == 1'b0);
        ea  = sgn ? {{32{a[31]}}, a} : {32'h0, a};
        eb  = sgn ? {{32{b[31]}}, b} : {32'h0, b};
        p   = ea * eb;
        cur = {mhi[idx], mlo[idx]};
        if (op == 6'b000000)  cur = p;
        else if (fn[2] == 1'b0) cur = cur + p;
        else                  cur = cur - p;
        mhi[idx] = cur[63:32];
        mlo[idx] = cur[31:0];
        issue(enc_acc(op, fn, idx), a, b);
    endtask

    task automatic mt_word(input bit hi, input [1:0] idx, input [31:0] v);
        if (hi) mhi[idx] = v; else mlo[idx] = v;
        issue(enc_mt(hi ? 6'b010001 : 6'b010011, idx), v, 32'h5A5A5A5A);
    endtask

    task automatic rd_word(input bit hi, input [1:0] idx, input [4:0] rd, input string req);
        exp_t e;
        e.ill = 0; e.data = hi ? mhi[idx] : mlo[idx]; e.rd = rd; e.req = req;
        q.push_back(e);
        issue(enc_mf(hi ? 6'b010000 : 6'b010010, idx, rd), 32'hDEAD0000, 32'h1);
    endtask

    task automatic bad_word(input [31:0] ins, input string req);
        exp_t e;
        e.ill = 1; e.data = '0; e.rd = '0; e.req = req;
        q.push_back(e);
        issue(ins, 32'h12345678, 32'h9ABCDEF0);
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 4; i++) begin
            rd_word(1'b1, 2'(i), 5'(i + 1), req);
            rd_word(1'b0, 2'(i), 5'(i + 17), req);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        for (int i = 0; i < 4; i++) begin mhi[i] = '0; mlo[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        n_tests++;
        if (wr_en_o !== 1'b0 || illegal_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs en=%0b ill=%0b expected 0 0", wr_en_o, illegal_o);
        end
        rst = 1'b0;
        // R1: all words zero after reset
        read_all("R1");

        // R2: signed and unsigned overwrite
        mac_op(6'b000000, 6'b011000, 2'd1, 32'hFFFFFFFD, 32'd5);
        rd_word(1'b1, 2'd1, 5'd4, "R2"); rd_word(1'b0, 2'd1, 5'd5, "R2");
        mac_op(6'b000000, 6'b011001, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF);
        rd_word(1'b1, 2'd2, 5'd6, "R2"); rd_word(1'b0, 2'd2, 5'd7, "R2");

        // R3: add forms
        mac_op(6'b011100, 6'b000000, 2'd1, 32'h80000000, 32'h7FFFFFFF);
        rd_word(1'b1, 2'd1, 5'd8, "R3"); rd_word(1'b0, 2'd1, 5'd9, "R3");
        mac_op(6'b011100, 6'b000001, 2'd2, 32'h80000000, 32'h00000004);
        rd_word(1'b1, 2'd2, 5'd10, "R3"); rd_word(1'b0, 2'd2, 5'd11, "R3");

        // R4 R5: subtract below zero wraps to all ones region
        mac_op(6'b011100, 6'b000100, 2'd3, 32'd2, 32'd3);
        rd_word(1'b1, 2'd3, 5'd12, "R4"); rd_word(1'b0, 2'd3, 5'd13, "R4");
        mac_op(6'b011100, 6'b000101, 2'd3, 32'hFFFFFFFF, 32'd2);
        rd_word(1'b1, 2'd3, 5'd14, "R4"); rd_word(1'b0, 2'd3, 5'd15, "R4");

        // R7 R5: move-to one word, then unsigned add wraps past 2^64
        mt_word(1'b1, 2'd0, 32'hFFFFFFFF);
        rd_word(1'b1, 2'd0, 5'd16, "R7"); rd_word(1'b0, 2'd0, 5'd17, "R7");
        mt_word(1'b0, 2'd0, 32'hFFFFFFFF);
        rd_word(1'b1, 2'd0, 5'd18, "R7"); rd_word(1'b0, 2'd0, 5'd19, "R7");
        mac_op(6'b011100, 6'b000001, 2'd0, 32'd1, 32'd1);
        rd_word(1'b1, 2'd0, 5'd20, "R5"); rd_word(1'b0, 2'd0, 5'd21, "R5");

        // R8: other pairs untouched
        read_all("R8");

        // R9: reserved fields nonzero
        bad_word(enc_acc(6'b011100, 6'b000000, 2'd1) | 32'h0000_0080, "R9");
        bad_word(enc_mf(6'b010000, 2'd2, 5'd3) | 32'h0004_0000, "R9");
        bad_word(enc_mt(6'b010001, 2'd3) | 32'h0000_4000, "R9");
        bad_word(enc_acc(6'b000000, 6'b011000, 2'd1) | 32'h0000_2000, "R9");
        read_all("R9");

        // R10: unknown opcode/function pairs
        bad_word(enc_acc(6'b000000, 6'b011010, 2'd0), "R10");
        bad_word(enc_acc(6'b011100, 6'b000010, 2'd1), "R10");
        bad_word(enc_acc(6'b000100, 6'b011000, 2'd2), "R10");
        read_all("R10");

        // R11: valid low ignores a move-to and a multiply
        instr_i = enc_mt(6'b010001, 2'd1); rs_val_i = 32'hCAFEF00D; valid_i = 1'b0;
        @(posedge clk); #1;
        instr_i = enc_acc(6'b000000, 6'b011000, 2'd2); rt_val_i = 32'd7;
        @(posedge clk); #1;
        read_all("R11");

        // R8 R5: mixed sequence with back-to-back reads
        seed = 32'h1357_9BDF;
        for (int k = 0; k < 40; k++) begin
            logic [5:0] op, fn;
            logic [1:0] ix;
            seed = seed * 32'd1664525 + 32'd1013904223;
            ix = seed[9:8];
            case (seed[14:12] % 6)
                0: begin op = 6'b000000; fn = 6'b011000; end
                1: begin op = 6'b000000; fn = 6'b011001; end
                2: begin op = 6'b011100; fn = 6'b000000; end
                3: begin op = 6'b011100; fn = 6'b000001; end
                4: begin op = 6'b011100; fn = 6'b000100; end
                default: begin op = 6'b011100; fn = 6'b000101; end
            endcase
            mac_op(op, fn, ix, seed ^ 32'hA5A5_0F0F, {seed[15:0], seed[31:16]});
            rd_word(1'b1, ix, 5'd30, "R8"); rd_word(1'b0, ix, 5'd31, "R8");
        end
        read_all("R8");

        repeat (2) @(posedge clk);
        #1;
        n_tests++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R6 missing outputs: %0d pending expected 0", q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule